// File: doc/BRIEF.md
# Sensor Alert Classification Controller

The block collects a set of sensor alert event lines and sorts each event into one of two classes, fatal or recoverable, according to a mask that software programs through a small register port. Every event is latched into a flag bit of its class. Recoverable flags can be cleared by software. Fatal flags stay set until reset, and one extra fatal flag records a local fatal event. Two aggregate alert outputs follow the flag registers, so an alert handler downstream sees one line per class.

Software can lock the classification mask for the rest of the reset period. It can hold any alert line active through a persistent trigger register, and it can inject a single alert pulse of either class. The block also samples an IO power-ok status vector and an init-done line. A change in either raises a write-1-to-clear interrupt, and each interrupt has its own enable and test bit.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where the write enable is high. Reads are combinational from the word address. Address bits 1:0 are ignored.

Top module: `sensor_alert_classifier`

## Requirements
- R1: After reset every register reads zero except the lock register at word 0x10, which reads 1. Both alert outputs and both interrupt outputs are low.
- R2: A pulse on alert line i whose class bit is 0 in the mask (word 0x18) sets bit i of the recoverable flags (word 0x1C) at the next edge. The fatal flags do not change.
- R3: A pulse on alert line i whose class bit is 1 sets bit i of the fatal flags (word 0x20) at the next edge. The recoverable flags do not change.
- R4: Writing 1 to a recoverable flag bit clears it and writing 0 leaves it alone. If an event sets the same bit in the same cycle as the clear, the bit stays set.
- R5: No write can clear the fatal flags. A pulse on the local fatal input sets bit 11 (the bit just above the alert bits).
- R6: The lock register is cleared by writing 0 to bit 0. Writing 1 does not set it again. While it is 0, writes to the mask are ignored until reset.
- R7: While bit i of the trigger register (word 0x14, read/write) is 1, alert i acts as if asserted on every cycle and is classified by the mask.
- R8: In the alert-test register (word 0x0C, write-only), writing 1 to bit 0 pulses the recoverable alert output for one cycle and writing 1 to bit 1 pulses the fatal alert output for one cycle. Neither write sets any flag.
- R9: The recoverable output is high while any recoverable flag is set or a recoverable test pulse is active. The fatal output follows the same rule for fatal flags and fatal test pulses.
- R10: The status register (word 0x24, read-only) holds the sampled init-done value in bit 0 and the IO power-ok value in bits 2:1, one edge after the inputs change.
- R11: The interrupt state (word 0x00, rw1c) sets bit 0 when the IO power-ok value changes and bit 1 when init-done changes. Writing 1 to the matching bit of the test register (word 0x08) sets the same state bit. A hardware set wins over a clear in the same cycle.
- R12: Each interrupt output is high when its state bit and its enable bit (word 0x04) are both 1.
- R13: Write-only words, unmapped words and reserved bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alertEvent | input | NUM_ALERTS | Sensor alert event lines |
| localFatalEvt | input | 1 | Local fatal event, recorded in the top fatal flag bit |
| ioPok | input | POK_W | IO power-ok status |
| initDone | input | 1 | Initialisation-done status |
| regWe | input | 1 | Register write enable |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data |
| recovAlert | output | 1 | Aggregate recoverable alert |
| fatalAlert | output | 1 | Aggregate fatal alert |
| irqIoChange | output | 1 | Interrupt: IO power status changed |
| irqInitChange | output | 1 | Interrupt: init status changed |

## Verification
The bench builds the block with its defaults: 11 alert lines, a 2-bit power-ok vector, a 6-bit address and 32-bit data. At this width an all-ones alert pattern, the top alert bit, the local fatal bit just above the alert bits and the three-bit status word can all be driven and read in full. The classification vectors mix masks and alert patterns so that recoverable and fatal bits land in the same pulse. Directed tests then cover the set-wins collision, the trigger holding a flag against a clear, and the lock that cannot be re-armed.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [3:0] {
    SelIntrState  = 4'd0,
    SelIntrEnable = 4'd1,
    SelIntrTest   = 4'd2,
    SelAlertTest  = 4'd3,
    SelCfgEn      = 4'd4,
    SelTrig       = 4'd5,
    SelFatalEn    = 4'd6,
    SelRecov      = 4'd7,
    SelFatal      = 4'd8,
    SelStatus     = 4'd9,
    SelNone       = 4'd15
  } regSel_e;

  localparam int unsigned NUM_REGS = 10;
  localparam int unsigned SEL_W    = $bits(regSel_e);

  typedef struct packed {
    logic    wrIntrState;
    logic    wrIntrEnable;
    logic    wrIntrTest;
    logic    wrAlertTest;
    logic    wrCfgEn;
    logic    wrTrig;
    logic    wrFatalEn;
    logic    wrRecov;
    regSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/sac_ctrl.sv
module sac_ctrl
  import sac_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             unusedByteSel;
  regSel_e          sel;

  assign wordIdx       = regAddr[ADDR_W-1:2];
  assign unusedByteSel = ^regAddr[1:0];

  always_comb begin
    if (wordIdx < IDX_W'(NUM_REGS)) sel = regSel_e'(wordIdx[SEL_W-1:0]);
    else                            sel = SelNone;
  end

  always_comb begin
    strobe              = '0;
    strobe.sel          = sel;
    strobe.wrIntrState  = regWe && (sel == SelIntrState);
    strobe.wrIntrEnable = regWe && (sel == SelIntrEnable);
    strobe.wrIntrTest   = regWe && (sel == SelIntrTest);
    strobe.wrAlertTest  = regWe && (sel == SelAlertTest);
    strobe.wrCfgEn      = regWe && (sel == SelCfgEn);
    strobe.wrTrig       = regWe && (sel == SelTrig);
    strobe.wrFatalEn    = regWe && (sel == SelFatalEn);
    strobe.wrRecov      = regWe && (sel == SelRecov);
  end

endmodule

// File: rtl/sac_datapath.sv
module sac_datapath
  import sac_pkg::*;
#(
  parameter int unsigned NUM_ALERTS = 11,
  parameter int unsigned POK_W      = 2,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_ALERTS-1:0] alertEvent,
  input  logic                  localFatalEvt,
  input  logic [POK_W-1:0]      ioPok,
  input  logic                  initDone,
  output logic [DATA_W-1:0]     rdata,
  output logic                  recovAlert,
  output logic                  fatalAlert,
  output logic [1:0]            irq,
  output logic [NUM_ALERTS-1:0] recovQ,
  output logic [NUM_ALERTS:0]   fatalQ,
  output logic [NUM_ALERTS-1:0] fatalEnQ,
  output logic                  cfgEnQ,
  output logic [1:0]            intrStateQ
);

  localparam int unsigned STAT_W = POK_W + 1;

  logic [NUM_ALERTS-1:0] trigQ;
  logic [NUM_ALERTS-1:0] evt;
  logic [NUM_ALERTS-1:0] recovClr;
  logic [1:0]            intrEnQ;
  logic [1:0]            intrSet;
  logic [1:0]            intrClr;
  logic [STAT_W-1:0]     statQ;
  logic                  recovTestQ;
  logic                  fatalTestQ;
  logic                  unusedWdata;

  assign unusedWdata = ^wdata[DATA_W-1:NUM_ALERTS];

  // Trigger bits behave as continuously asserted alert lines.
  assign evt      = alertEvent | trigQ;
  assign recovClr = strobe.wrRecov ? wdata[NUM_ALERTS-1:0] : '0;

  // Per-alert flag slices: set wins over a software clear.
  for (genvar i = 0; i < NUM_ALERTS; i++) begin : gSlice
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        recovQ[i] <= 1'b0;
        fatalQ[i] <= 1'b0;
      end else begin
        recovQ[i] <= (recovQ[i] & ~recovClr[i]) | (evt[i] & ~fatalEnQ[i]);
        fatalQ[i] <= fatalQ[i] | (evt[i] & fatalEnQ[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fatalQ[NUM_ALERTS] <= 1'b0;
      fatalEnQ           <= '0;
      cfgEnQ             <= 1'b1;
      trigQ              <= '0;
      recovTestQ         <= 1'b0;
      fatalTestQ         <= 1'b0;
    end else begin
      fatalQ[NUM_ALERTS] <= fatalQ[NUM_ALERTS] | localFatalEvt;
      if (strobe.wrFatalEn && cfgEnQ) fatalEnQ <= wdata[NUM_ALERTS-1:0];
      if (strobe.wrCfgEn && !wdata[0]) cfgEnQ <= 1'b0;
      if (strobe.wrTrig) trigQ <= wdata[NUM_ALERTS-1:0];
      recovTestQ <= strobe.wrAlertTest & wdata[0];
      fatalTestQ <= strobe.wrAlertTest & wdata[1];
    end
  end

  assign recovAlert = (|recovQ) | recovTestQ;
  assign fatalAlert = (|fatalQ) | fatalTestQ;

  // Status sampling and change-detect interrupts (bit0 io, bit1 init).
  assign intrSet = {initDone != statQ[0], ioPok != statQ[STAT_W-1:1]}
                 | (strobe.wrIntrTest ? wdata[1:0] : 2'b00);
  assign intrClr = strobe.wrIntrState ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ      <= '0;
      intrStateQ <= '0;
      intrEnQ    <= '0;
    end else begin
      statQ      <= {ioPok, initDone};
      intrStateQ <= (intrStateQ & ~intrClr) | intrSet;
      if (strobe.wrIntrEnable) intrEnQ <= wdata[1:0];
    end
  end

  assign irq = intrStateQ & intrEnQ;

  always_comb begin
    unique case (strobe.sel)
      SelIntrState:  rdata = DATA_W'(intrStateQ);
      SelIntrEnable: rdata = DATA_W'(intrEnQ);
      SelCfgEn:      rdata = DATA_W'(cfgEnQ);
      SelTrig:       rdata = DATA_W'(trigQ);
      SelFatalEn:    rdata = DATA_W'(fatalEnQ);
      SelRecov:      rdata = DATA_W'(recovQ);
      SelFatal:      rdata = DATA_W'(fatalQ);
      SelStatus:     rdata = DATA_W'(statQ);
      default:       rdata = '0;
    endcase
  end

endmodule

// File: rtl/sensor_alert_classifier.sv
module sensor_alert_classifier
  import sac_pkg::*;
#(
  parameter int unsigned NUM_ALERTS = 11,
  parameter int unsigned POK_W      = 2,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ALERTS-1:0] alertEvent,
  input  logic                  localFatalEvt,
  input  logic [POK_W-1:0]      ioPok,
  input  logic                  initDone,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  recovAlert,
  output logic                  fatalAlert,
  output logic                  irqIoChange,
  output logic                  irqInitChange
);

  ctrlStrobe_t           strobe;
  logic [1:0]            irq;
  logic [NUM_ALERTS-1:0] recovFlags;
  logic [NUM_ALERTS:0]   fatalFlags;
  logic [NUM_ALERTS-1:0] fatalEn;
  logic                  cfgEn;
  logic [1:0]            intrState;

  sac_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  sac_datapath #(
    .NUM_ALERTS (NUM_ALERTS),
    .POK_W      (POK_W),
    .DATA_W     (DATA_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wdata         (regWdata),
    .alertEvent    (alertEvent),
    .localFatalEvt (localFatalEvt),
    .ioPok         (ioPok),
    .initDone      (initDone),
    .rdata         (regRdata),
    .recovAlert    (recovAlert),
    .fatalAlert    (fatalAlert),
    .irq           (irq),
    .recovQ        (recovFlags),
    .fatalQ        (fatalFlags),
    .fatalEnQ      (fatalEn),
    .cfgEnQ        (cfgEn),
    .intrStateQ    (intrState)
  );

  assign irqIoChange   = irq[0];
  assign irqInitChange = irq[1];

endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int unsigned NUM_ALERTS = 11,
  parameter int unsigned POK_W      = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_ALERTS-1:0] alertEvent,
  input logic [POK_W-1:0]      ioPok,
  input logic [NUM_ALERTS-1:0] recovFlags,
  input logic [NUM_ALERTS:0]   fatalFlags,
  input logic [NUM_ALERTS-1:0] fatalEn,
  input logic                  cfgEn,
  input logic [1:0]            intrState,
  input logic                  recovAlert,
  input logic                  fatalAlert
);

  a_r2_recov_latch: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((recovFlags & $past(alertEvent & ~fatalEn)) == $past(alertEvent & ~fatalEn)));

  a_r3_fatal_latch: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((fatalFlags[NUM_ALERTS-1:0] & $past(alertEvent & fatalEn)) == $past(alertEvent & fatalEn)));

  a_r5_fatal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((fatalFlags & $past(fatalFlags)) == $past(fatalFlags)));

  a_r6_lock_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> !cfgEn);

  a_r6_mask_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(fatalEn));

  a_r9_recov_out: assert property (@(posedge clk) disable iff (!rstN)
    (|recovFlags) |-> recovAlert);

  a_r9_fatal_out: assert property (@(posedge clk) disable iff (!rstN)
    (|fatalFlags) |-> fatalAlert);

  a_r11_io_change: assert property (@(posedge clk) disable iff (!rstN)
    (ioPok != $past(ioPok)) |=> intrState[0]);

endmodule

bind sensor_alert_classifier sac_checker #(
  .NUM_ALERTS (NUM_ALERTS),
  .POK_W      (POK_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .alertEvent (alertEvent),
  .ioPok      (ioPok),
  .recovFlags (recovFlags),
  .fatalFlags (fatalFlags),
  .fatalEn    (fatalEn),
  .cfgEn      (cfgEn),
  .intrState  (intrState),
  .recovAlert (recovAlert),
  .fatalAlert (fatalAlert)
);

// File: tb/tb_sensor_alert_classifier.sv
module tb_sensor_alert_classifier;

  localparam int unsigned NA = 11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] alertEvent = '0;
  logic        localFatalEvt = 1'b0;
  logic [1:0]  ioPok = '0;
  logic        initDone = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        recovAlert, fatalAlert, irqIoChange, irqInitChange;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rv;
  logic [11:0] expFatal = '0;

  // {alerts, mask, expected recoverable flags}
  localparam logic [32:0] VEC [6] = '{
    {11'h001, 11'h000, 11'h001},
    {11'h7FF, 11'h000, 11'h7FF},
    {11'h003, 11'h002, 11'h001},
    {11'h400, 11'h400, 11'h000},
    {11'h555, 11'h0F0, 11'h505},
    {11'h000, 11'h7FF, 11'h000}
  };

  sensor_alert_classifier dut (
    .clk(clk), .rstN(rstN), .alertEvent(alertEvent), .localFatalEvt(localFatalEvt),
    .ioPok(ioPok), .initDone(initDone), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .recovAlert(recovAlert),
    .fatalAlert(fatalAlert), .irqIoChange(irqIoChange), .irqInitChange(irqInitChange)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), rv);
      chk("R1 reset reg", rv, (a == 4) ? 32'h1 : 32'h0);
    end
    chk("R1 reset outputs", {28'h0, recovAlert, fatalAlert, irqIoChange, irqInitChange}, 32'h0);

    // R8 alert test pulses
    wr(6'h0C, 32'h1);
    #1;
    chk("R8 recov pulse", {30'h0, recovAlert, fatalAlert}, 32'h2);
    @(negedge clk); #1;
    chk("R8 recov pulse ends", {31'h0, recovAlert}, 32'h0);
    wr(6'h0C, 32'h2);
    #1;
    chk("R8 fatal pulse", {30'h0, recovAlert, fatalAlert}, 32'h1);
    @(negedge clk);
    rd(6'h1C, rv); chk("R8 no recov flag", rv, 32'h0);
    rd(6'h20, rv); chk("R8 no fatal flag", rv, 32'h0);
    chk("R9 fatal out idle", {31'h0, fatalAlert}, 32'h0);

    // R10 R11 R12 status and interrupts
    wr(6'h04, 32'h3);
    ioPok = 2'b01;
    @(negedge clk);
    rd(6'h24, rv); chk("R10 status io", rv, 32'h2);
    rd(6'h00, rv); chk("R11 io change", rv, 32'h1);
    chk("R12 irq io", {31'h0, irqIoChange}, 32'h1);
    wr(6'h00, 32'h1);
    rd(6'h00, rv); chk("R11 rw1c", rv, 32'h0);
    initDone = 1'b1;
    @(negedge clk);
    rd(6'h00, rv); chk("R11 init change", rv, 32'h2);
    rd(6'h24, rv); chk("R10 status both", rv, 32'h3);
    chk("R12 irq init", {31'h0, irqInitChange}, 32'h1);
    wr(6'h04, 32'h0);
    chk("R12 irq masked", {30'h0, irqInitChange, irqIoChange}, 32'h0);
    wr(6'h00, 32'h3);
    wr(6'h08, 32'h1);
    rd(6'h00, rv); chk("R11 test set", rv, 32'h1);
    wr(6'h00, 32'h1);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, rv); chk("R13 enable reserved", rv, 32'h3);
    wr(6'h04, 32'h0);

    // R2 R3 R9 classification table
    foreach (VEC[v]) begin
      logic [10:0] al, fen, expR;
      {al, fen, expR} = VEC[v];
      wr(6'h18, 32'(fen));
      alertEvent = al;
      @(negedge clk);
      alertEvent = '0;
      expFatal = expFatal | {1'b0, al & fen};
      rd(6'h1C, rv); chk("R2 recov flags", rv, 32'(expR));
      rd(6'h20, rv); chk("R3 fatal flags", rv, 32'(expFatal));
      chk("R9 outputs", {30'h0, recovAlert, fatalAlert},
          {30'h0, expR != 0, expFatal != 0});
      wr(6'h1C, 32'h7FF);
      rd(6'h1C, rv); chk("R4 clear", rv, 32'h0);
      chk("R9 recov out low", {31'h0, recovAlert}, 32'h0);
    end

    // R4 set wins over clear
    wr(6'h18, 32'h0);
    alertEvent = 11'h008;
    wr(6'h1C, 32'h008);
    alertEvent = '0;
    rd(6'h1C, rv); chk("R4 set wins", rv, 32'h008);
    wr(6'h1C, 32'h008);
    rd(6'h1C, rv); chk("R4 clear after", rv, 32'h0);

    // R5 fatal sticky and local event
    wr(6'h20, 32'hFFF);
    rd(6'h20, rv); chk("R5 no clear", rv, 32'(expFatal));
    localFatalEvt = 1'b1;
    @(negedge clk);
    localFatalEvt = 1'b0;
    expFatal[11] = 1'b1;
    rd(6'h20, rv); chk("R5 local bit", rv, 32'(expFatal));

    // R7 persistent trigger
    wr(6'h14, 32'h010);
    @(negedge clk);
    rd(6'h1C, rv); chk("R7 trig sets", rv, 32'h010);
    wr(6'h1C, 32'h010);
    rd(6'h1C, rv); chk("R7 trig holds", rv, 32'h010);
    rd(6'h14, rv); chk("R7 trig readback", rv, 32'h010);
    wr(6'h14, 32'h0);
    wr(6'h1C, 32'h010);
    rd(6'h1C, rv); chk("R7 trig released", rv, 32'h0);
    wr(6'h18, 32'h020);
    wr(6'h14, 32'h020);
    wr(6'h14, 32'h0);
    expFatal[5] = 1'b1;
    rd(6'h20, rv); chk("R7 trig fatal", rv, 32'(expFatal));
    rd(6'h1C, rv); chk("R7 trig no recov", rv, 32'h0);

    // R6 configuration lock
    wr(6'h10, 32'h1);
    rd(6'h10, rv); chk("R6 write1 keeps", rv, 32'h1);
    wr(6'h18, 32'h123);
    rd(6'h18, rv); chk("R6 mask open", rv, 32'h123);
    wr(6'h10, 32'h0);
    rd(6'h10, rv); chk("R6 locked", rv, 32'h0);
    wr(6'h18, 32'h0);
    rd(6'h18, rv); chk("R6 mask frozen", rv, 32'h123);
    wr(6'h10, 32'h1);
    rd(6'h10, rv); chk("R6 no rearm", rv, 32'h0);

    // R13 write-only and unmapped reads
    rd(6'h08, rv); chk("R13 intr test reads 0", rv, 32'h0);
    rd(6'h0C, rv); chk("R13 alert test reads 0", rv, 32'h0);
    rd(6'h28, rv); chk("R13 unmapped 0x28", rv, 32'h0);
    rd(6'h3C, rv); chk("R13 unmapped 0x3C", rv, 32'h0);

    // R1 reset clears sticky state
    ioPok = '0; initDone = 1'b0;
    doReset();
    rd(6'h20, rv); chk("R1 fatal after reset", rv, 32'h0);
    rd(6'h10, rv); chk("R1 lock after reset", rv, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule